// File: doc/BRIEF.md
# Dual-Channel Event Performance Counter

This block gives a small processor two independent hardware event counters. Each channel has a 16-bit control word and a 48-bit running count. The control word picks one event source by a 6-bit code, gates counting with two separate bits (enable and start), and offers a self-clearing bit that zeroes the count. Software reads the count as two words: a high word that carries the upper 16 bits and a low word that carries the lower 32 bits.

Event sources arrive as one-cycle pulse inputs, one per code position. The elapsed-time code takes its time base from the block's own tick inputs: a fast cycle tick, or a slower tick when the clock-select flag is set. Only part of the code space is populated. A code with no event behind it counts nothing. Counters wrap silently and raise no flag.

The host reaches the block over a simple single-cycle register bus. Address bit 2 picks the channel. Address bits [1:0] pick the word: 0 is control, 1 is count high and 2 is count low. Word 3 reads as zero.

Top module: `evt_perf_mon`

## Requirements
- R1: After reset, both control words read 0 and both counts read 0 in both the high and the low words.
- R2: A control write keeps bits 15 (enable), 14 (start), 8 (clock select) and [5:0] (event code). On readback all other bits, including bit 13, are 0. Bits [31:16] of a control read are 0.
- R3: A count advances by exactly 1 on each clock edge at which bits 15 and 14 are both set in the stored control word and the selected event is high. With either bit clear, the count holds.
- R4: The event code selects `evt_in[code]`. Each channel uses only its own code, so a channel ignores pulses on inputs that the other channel selects.
- R5: The event codes 0x00, 0x0C, 0x1B to 0x20, 0x26 and 0x2A to 0x3F are unused. While such a code is selected, the count holds even with every event input and tick high.
- R6: A control write with bit 13 set zeroes that channel's count at that edge. This holds even when the selected event pulses in the same cycle.
- R7: Word 1 returns count bits [CNT_W-1:32], zero-extended. Word 2 returns count bits [31:0].
- R8: A count at its all-ones value that takes one more event becomes 0.
- R9: Code 0x23 counts `cyc_tick` while bit 8 is 0 and `slow_tick` while bit 8 is 1. For this code `evt_in[35]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | [2] channel, [1:0] word select |
| bus_wdata | input | 16 | Control write data |
| bus_rdata | output | 32 | Read data, same cycle, 0 when not reading |
| evt_in | input | 64 | Event pulses, indexed by event code |
| cyc_tick | input | 1 | Fast time base for the elapsed-time code |
| slow_tick | input | 1 | Slow time base for the elapsed-time code |

## Verification
Faults in the gate or the select logic show up within one cycle, but only as a count that has drifted. A missed or extra step stays in the count for good and appears at the next read of the low word. Because of this, every scenario ends with a read of the exact count. The bench also times events to land on the same edge as a clearing write, and drives many inputs high at once, so that a wrong priority or a leak from another input changes that count. Faults in the upper bits show only after a carry into the high word. A narrowed second instance takes that carry, and then a full wrap, within a few thousand cycles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int SEL_W = 6;
  localparam int NUM_EVT = 2 ** SEL_W;
  localparam logic [SEL_W-1:0] CODE_ELAPSED = 6'h23;
  localparam logic [15:0] CTRL_KEEP = 16'hC13F;
  localparam int BIT_EN = 15;
  localparam int BIT_ST = 14;
  localparam int BIT_CLR = 13;
  localparam int BIT_CLKF = 8;

  // Populated codes of the sparse event map.
  function automatic logic code_used(input logic [SEL_W-1:0] c);
    return (c >= 6'h01 && c <= 6'h0b) || (c >= 6'h0d && c <= 6'h1a) ||
           (c >= 6'h21 && c <= 6'h25) || (c >= 6'h27 && c <= 6'h29);
  endfunction
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] ctrl_q,
  output logic        clr_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & CTRL_KEEP;
  end

  // The clear request acts in the write cycle and is never stored.
  assign clr_pulse = wr_en & wdata[BIT_CLR];
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
  import pmu_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic               clkf,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               cyc_tick,
  input  logic               slow_tick,
  output logic               hit
);
  always_comb begin
    if (!code_used(sel)) hit = 1'b0;
    else if (sel == CODE_ELAPSED) hit = clkf ? slow_tick : cyc_tick;
    else hit = evt_in[sel];
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic do_clr,
                                                input logic step);
    if (do_clr) return '0;
    if (step) return c + CNT_W'(1);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else count <= cnt_next(count, clr, run & hit);
  end
endmodule

// File: rtl/evt_perf_mon.sv
module evt_perf_mon
  import pmu_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int LO_W  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [63:0] evt_in,
  input  logic        cyc_tick,
  input  logic        slow_tick
);
  localparam int NCH = 2;
  localparam int HI_W = CNT_W - LO_W;

  // Named internal events, used by the bound checker.
  logic [NCH-1:0]            ch_run;
  logic [NCH-1:0]            ch_hit;
  logic [NCH-1:0]            ch_clr;
  logic [NCH-1:0][SEL_W-1:0] ch_sel;
  logic [NCH-1:0][15:0]      ch_ctrl;
  logic [NCH-1:0][CNT_W-1:0] cnt_q;

  logic       rd_ch;
  logic [1:0] rd_word;
  assign rd_ch   = bus_addr[2];
  assign rd_word = bus_addr[1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_here;
    assign wr_here = bus_sel & bus_wr & (rd_word == 2'd0) & (rd_ch == 1'(i));

    pmu_ctrl_reg u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_here), .wdata(bus_wdata),
      .ctrl_q(ch_ctrl[i]), .clr_pulse(ch_clr[i])
    );

    assign ch_sel[i] = ch_ctrl[i][SEL_W-1:0];
    assign ch_run[i] = ch_ctrl[i][BIT_EN] & ch_ctrl[i][BIT_ST];

    pmu_evt_sel u_sel (
      .sel(ch_sel[i]), .clkf(ch_ctrl[i][BIT_CLKF]), .evt_in(evt_in),
      .cyc_tick(cyc_tick), .slow_tick(slow_tick), .hit(ch_hit[i])
    );

    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(ch_clr[i]), .run(ch_run[i]),
      .hit(ch_hit[i]), .count(cnt_q[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (rd_word)
        2'd0: bus_rdata = {16'h0, ch_ctrl[rd_ch]};
        2'd1: bus_rdata = 32'(cnt_q[rd_ch][CNT_W-1:LO_W]);
        2'd2: bus_rdata = 32'(cnt_q[rd_ch][LO_W-1:0]);
        default: bus_rdata = '0;
      endcase
    end
  end

  if (HI_W > 32 || LO_W > 32 || HI_W < 1) begin : g_bad_split
    initial $error("count split does not fit the 32-bit read port");
  end
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
  import pmu_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 48
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            ch_run,
  input logic [NCH-1:0]            ch_hit,
  input logic [NCH-1:0]            ch_clr,
  input logic [NCH-1:0][SEL_W-1:0] ch_sel,
  input logic [NCH-1:0][CNT_W-1:0] cnt_q,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input logic [2:0]                bus_addr,
  input logic [31:0]               bus_rdata
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ch_clr[i] |=> cnt_q[i] == '0);
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_clr[i] && ch_run[i] && ch_hit[i]) |=> cnt_q[i] == CNT_W'($past(cnt_q[i]) + CNT_W'(1)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_clr[i] && !(ch_run[i] && ch_hit[i])) |=> $stable(cnt_q[i]));
    p_unused_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !code_used(ch_sel[i]) |-> !ch_hit[i]);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_clr[i] && ch_run[i] && ch_hit[i] && cnt_q[i] == '1) |=> cnt_q[i] == '0);
  end

  p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1:0] == 2'd0) |-> (bus_rdata[31:16] == 16'h0 && !bus_rdata[13]));
endmodule

bind evt_perf_mon pmu_chk #(.NCH(2), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_run(ch_run), .ch_hit(ch_hit), .ch_clr(ch_clr),
  .ch_sel(ch_sel), .cnt_q(cnt_q), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/evt_perf_mon_tb_top.sv
module evt_perf_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a = 1'b0, sel_w = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_w;
  logic [63:0] evt_in = '0;
  logic        cyc_tick = 1'b0, slow_tick = 1'b0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_perf_mon dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .evt_in(evt_in),
    .cyc_tick(cyc_tick), .slow_tick(slow_tick)
  );

  // Narrow instance: 12-bit count split 4/8, to reach carry and wrap quickly.
  evt_perf_mon #(.CNT_W(12), .LO_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_w), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_w), .evt_in(evt_in),
    .cyc_tick(cyc_tick), .slow_tick(slow_tick)
  );

  typedef struct {
    bit          narrow;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d, input bit narrow = 1'b0);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (narrow) sel_w = 1'b1; else sel_a = 1'b1;
    @(negedge clk);
    sel_a = 1'b0; sel_w = 1'b0; bus_wr = 1'b0;
  endtask

  // Driver: puts the read on the bus and queues the value the requirements predict.
  task automatic rd_expect(input logic [2:0] a, input logic [31:0] e, input string tag,
                           input bit narrow = 1'b0);
    exp_t it;
    it.narrow = narrow; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_wr = 1'b0;
    if (narrow) sel_w = 1'b1; else sel_a = 1'b1;
    @(negedge clk);
    sel_a = 1'b0; sel_w = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    evt_in[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt_in[idx] = 1'b0;
  endtask

  // Monitor: compares each bus read, 5 ns after the driver has set it up.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if ((sel_a || sel_w) && !bus_wr) begin
        exp_t it;
        logic [31:0] got;
        if (sb_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL scoreboard: read with nothing queued");
        end else begin
          it = sb_q.pop_front();
          got = it.narrow ? rdata_w : rdata_a;
          n_tests++;
          if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_expect(3'd0, 32'h0, "R1 ctrl0");
    rd_expect(3'd4, 32'h0, "R1 ctrl1");
    rd_expect(3'd1, 32'h0, "R1 hi0");
    rd_expect(3'd2, 32'h0, "R1 lo0");
    rd_expect(3'd6, 32'h0, "R1 lo1");

    // R2 readback mask and R5 unused code 0x3F with every input high
    wr_reg(3'd0, 16'hFFFF);
    rd_expect(3'd0, 32'h0000_C13F, "R2 ctrl0 mask");
    evt_in = '1; cyc_tick = 1'b1; slow_tick = 1'b1;
    repeat (5) @(negedge clk);
    evt_in = '0; cyc_tick = 1'b0; slow_tick = 1'b0;
    rd_expect(3'd2, 32'h0, "R5 code 3F holds");
    wr_reg(3'd0, 16'hC00C);
    evt_in = '1; repeat (3) @(negedge clk); evt_in = '0;
    rd_expect(3'd2, 32'h0, "R5 code 0C holds");
    wr_reg(3'd0, 16'hC026);
    evt_in = '1; repeat (3) @(negedge clk); evt_in = '0;
    rd_expect(3'd2, 32'h0, "R5 code 26 holds");

    // R3 enable without start holds; R4 second channel on its own code
    wr_reg(3'd0, 16'h8001);
    wr_reg(3'd4, 16'hC002);
    pulse(1, 3);
    rd_expect(3'd2, 32'h0, "R3 enable only");
    pulse(2, 2);
    rd_expect(3'd6, 32'd2, "R4 ch1 own code");
    rd_expect(3'd2, 32'h0, "R4 ch0 ignores code 2");
    wr_reg(3'd0, 16'hC001);
    pulse(1, 4);
    rd_expect(3'd2, 32'd4, "R3 four steps");
    rd_expect(3'd1, 32'h0, "R7 hi0 small count");
    rd_expect(3'd6, 32'd2, "R4 ch1 ignores code 1");

    // R6 clear in the same cycle as an event
    evt_in[1] = 1'b1;
    wr_reg(3'd0, 16'hE001);
    evt_in[1] = 1'b0;
    rd_expect(3'd2, 32'h0, "R6 clear wins");
    rd_expect(3'd0, 32'h0000_C001, "R2 clear bit reads 0");
    pulse(1, 1);
    rd_expect(3'd2, 32'd1, "R6 counts after clear");

    // R9 elapsed time: fast tick, then slow tick
    wr_reg(3'd4, 16'hE023);
    cyc_tick = 1'b1; slow_tick = 1'b1; evt_in[35] = 1'b1;
    repeat (2) @(negedge clk);
    slow_tick = 1'b0; evt_in[35] = 1'b0;
    repeat (4) @(negedge clk);
    cyc_tick = 1'b0;
    rd_expect(3'd6, 32'd6, "R9 fast base");
    wr_reg(3'd4, 16'hE123);
    cyc_tick = 1'b1; slow_tick = 1'b1;
    repeat (2) @(negedge clk);
    slow_tick = 1'b0; evt_in[35] = 1'b1;
    repeat (4) @(negedge clk);
    cyc_tick = 1'b0; evt_in[35] = 1'b0;
    rd_expect(3'd6, 32'd2, "R9 slow base");
    rd_expect(3'd4, 32'h0000_C123, "R2 ctrl1 clkf");

    // R7 split and R8 wrap on the narrow instance
    rd_expect(3'd2, 32'h0, "R1 narrow lo0", 1'b1);
    wr_reg(3'd0, 16'hC001, 1'b1);
    pulse(1, 300);
    rd_expect(3'd1, 32'h1, "R7 narrow hi", 1'b1);
    rd_expect(3'd2, 32'h2C, "R7 narrow lo", 1'b1);
    pulse(1, 3801);
    rd_expect(3'd1, 32'h0, "R8 wrap hi", 1'b1);
    rd_expect(3'd2, 32'h5, "R8 wrap lo", 1'b1);

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: %0d reads left, expected 0", sb_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule